// File: doc/BRIEF.md
# Ethernet MAC Control Register Bank

This block is the software-visible register bank of an Ethernet MAC. It sits on a simple 32-bit request port and decodes word-aligned reads and writes at an offset from a base address. It holds the MAC's configuration words: mode, interrupt source and mask, three inter-packet gap values, the frame length limits, collision settings, the transmit descriptor count, control mode and the MII management words. Two registers hold the six-byte station address, and a window of descriptor RAM lets software write and read buffer descriptors.

The transmit logic receives three things from the bank: the live mode word, the minimum and maximum frame lengths, and the station address as one 48-bit vector. Any access that is misaligned, falls outside the block's span, or hits an unmapped word inside the span raises a one-cycle error pulse. Such an access changes no state, and a read of it returns zero. Every read request returns registered data one cycle later, together with a valid strobe.

Top module: `mac_regbank`

## Requirements
- R1: After reset the registers read as follows: mode 0x0000A000, transmit gap (offset 0x0C) 0x12, gap 1 (0x10) 0x0C, gap 2 (0x14) 0x12, collision configuration (0x1C) 0x000F003F, MII mode (0x28) 0x64 and transmit descriptor count (0x20) 0x80. Every other register (offsets 0x04, 0x08, 0x24, 0x2C to 0x44) reads zero.
- R2: The frame length register (offset 0x18) resets to 0x003C0600. Bits 31:16 drive `min_len_o` (60 after reset) and bits 15:0 drive `max_len_o` (1536 after reset).
- R3: Station address word 0 (offset 0x40) stores address byte 0 from bits 7:0, byte 1 from 15:8, byte 2 from 23:16 and byte 3 from 31:24. It reads back with the same packing. Byte k appears on `station_addr_o[8k+7:8k]`.
- R4: Station address word 1 (offset 0x44) holds byte 4 in bits 7:0 and byte 5 in bits 15:8. Bits 31:16 always read zero, whatever was written.
- R5: An aligned access at offset 0x400 + 4*n, for n in 0 to BD_WORDS-1, writes or reads descriptor entry n.
- R6: An access whose address is not a multiple of 4, or whose address lies below the base or at or above base + SPAN_BYTES, is rejected. It writes nothing, and a read of it returns zero.
- R7: An aligned in-span address is illegal when it matches no register and is not in the descriptor window (offsets 0x48 to 0x3FC, and 0x400 + 4*BD_WORDS up to the span end). Writes to it are ignored and reads of it return zero.
- R8: `rd_valid` is high exactly in the cycle after each read request, with `rd_data` valid in that cycle. It is low at all other times.
- R9: `acc_err` is high for exactly one cycle, the cycle after each rejected or illegal request, whether read or write. Legal accesses never raise it.
- R10: A legal register write takes effect on the clock edge that accepts it. At most one register write strobe is active per cycle. A later read returns the written value, and `mode_o`, the length outputs and the station address follow from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read request) |
| rd_data | output | 32 | Read data |
| acc_err | output | 1 | One-cycle pulse after a rejected or illegal access |
| mode_o | output | 32 | Current mode register |
| min_len_o | output | 16 | Minimum frame length |
| max_len_o | output | 16 | Maximum frame length |
| station_addr_o | output | 48 | Station address, byte 0 in bits 7:0 |

## Verification
Every result of a request is due exactly one clock edge after the edge that samples it: `rd_valid`, `rd_data` and `acc_err` are all registered once, and a write is visible on the side outputs from that same edge. The bench drives each request on a falling edge and samples the outputs on the next falling edge, one edge after the request. It then checks that `rd_valid` and `acc_err` have dropped one cycle after that. Sweeps cover every register offset, every descriptor entry, each unmapped word of the span, and misaligned and out-of-span addresses. For each one the expected data is computed arithmetically from the offset.

// File: rtl/macreg_pkg.sv
package macreg_pkg;

  localparam int NUM_REGS = 18;
  localparam int RI_W     = $clog2(NUM_REGS);

  localparam int RI_MODE    = 0;
  localparam int RI_ISRC    = 1;
  localparam int RI_IMASK   = 2;
  localparam int RI_GAP_TX  = 3;
  localparam int RI_GAP1    = 4;
  localparam int RI_GAP2    = 5;
  localparam int RI_FRLEN   = 6;
  localparam int RI_COLL    = 7;
  localparam int RI_TXBD    = 8;
  localparam int RI_CTRL    = 9;
  localparam int RI_MIIMODE = 10;
  localparam int RI_MIICMD  = 11;
  localparam int RI_MIIADDR = 12;
  localparam int RI_MIIWD   = 13;
  localparam int RI_MIIRD   = 14;
  localparam int RI_MIIST   = 15;
  localparam int RI_STA_LO  = 16;
  localparam int RI_STA_HI  = 17;

  typedef enum logic [1:0] {
    ACC_BAD = 2'd0,
    ACC_REG = 2'd1,
    ACC_BD  = 2'd2
  } acc_kind_e;

  function automatic logic [31:0] reg_reset_value(input int idx);
    case (idx)
      RI_MODE:    return 32'h0000_A000;
      RI_GAP_TX:  return 32'h0000_0012;
      RI_GAP1:    return 32'h0000_000C;
      RI_GAP2:    return 32'h0000_0012;
      RI_FRLEN:   return 32'h003C_0600;
      RI_COLL:    return 32'h000F_003F;
      RI_TXBD:    return 32'h0000_0080;
      RI_MIIMODE: return 32'h0000_0064;
      default:    return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [31:0] reg_write_mask(input int idx);
    if (idx == RI_STA_HI) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

endpackage

// File: rtl/macreg_decode.sv
module macreg_decode
  import macreg_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR  = 32'h9000_0000,
  parameter int          SPAN_BYTES = 2048,
  parameter int          BD_OFFSET  = 1024,
  parameter int          BD_WORDS   = 128,
  localparam int         BD_AW      = $clog2(BD_WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [31:0]         req_addr,
  output acc_kind_e           kind,
  output logic [RI_W-1:0]     reg_idx,
  output logic [BD_AW-1:0]    bd_idx,
  output logic [NUM_REGS-1:0] reg_we,
  output logic                bd_we
);

  localparam logic [31:0] SPAN_L    = 32'(SPAN_BYTES);
  localparam logic [31:0] REG_BYTES = 32'(NUM_REGS * 4);
  localparam logic [31:0] BD_LO     = 32'(BD_OFFSET);
  localparam logic [31:0] BD_HI     = 32'(BD_OFFSET + BD_WORDS * 4);

  logic [31:0] rel;
  logic        in_span;
  logic        aligned;
  logic        wr_ok;

  always_comb begin
    rel     = req_addr - BASE_ADDR;
    in_span = (req_addr >= BASE_ADDR) && (rel < SPAN_L);
    aligned = (rel[1:0] == 2'b00);
    kind    = ACC_BAD;
    if (in_span && aligned) begin
      if (rel < REG_BYTES)                    kind = ACC_REG;
      else if ((rel >= BD_LO) && (rel < BD_HI)) kind = ACC_BD;
    end
    reg_idx = rel[RI_W+1:2];
    bd_idx  = rel[BD_AW+1:2];
    wr_ok   = req_valid && req_write;
    bd_we   = wr_ok && (kind == ACC_BD);
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_we
    assign reg_we[g] = wr_ok && (kind == ACC_REG) && (reg_idx == RI_W'(g));
  end

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_we, bd_we})); // R10

endmodule

// File: rtl/macreg_file.sv
module macreg_file
  import macreg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] reg_we,
  input  logic [31:0]         wdata,
  input  logic [RI_W-1:0]     rd_idx,
  output logic [31:0]         rd_value,
  output logic [31:0]         mode,
  output logic [31:0]         frame_len,
  output logic [47:0]         station
);

  logic [31:0] regs_q [NUM_REGS];
  logic [31:0] regs_d [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_comb begin
      regs_d[g] = regs_q[g];
      if (reg_we[g]) regs_d[g] = wdata & reg_write_mask(g);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         regs_q[g] <= reg_reset_value(g);
      else if (reg_we[g]) regs_q[g] <= regs_d[g];
    end
  end

  always_comb begin
    rd_value = 32'h0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == RI_W'(i)) rd_value = regs_q[i];
    end
  end

  assign mode      = regs_q[RI_MODE];
  assign frame_len = regs_q[RI_FRLEN];
  assign station   = {regs_q[RI_STA_HI][15:0], regs_q[RI_STA_LO]};

  AST_STA_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we[RI_STA_HI] |=> (station[47:32] == $past(wdata[15:0]))); // R4

endmodule

// File: rtl/macreg_bdram.sv
module macreg_bdram #(
  parameter int  BD_WORDS = 128,
  localparam int BD_AW    = $clog2(BD_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             re,
  input  logic [BD_AW-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);

  logic [31:0] mem [BD_WORDS];
  logic [31:0] rdata_d;

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  always_comb begin
    rdata_d = rdata;
    if (re) rdata_d = mem[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= 32'h0;
    else if (re) rdata <= rdata_d;
  end

  AST_BD_NO_RW_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re)); // R5

endmodule

// File: rtl/mac_regbank.sv
module mac_regbank
  import macreg_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR  = 32'h9000_0000,
  parameter int          SPAN_BYTES = 2048,
  parameter int          BD_OFFSET  = 1024,
  parameter int          BD_WORDS   = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        acc_err,
  output logic [31:0] mode_o,
  output logic [15:0] min_len_o,
  output logic [15:0] max_len_o,
  output logic [47:0] station_addr_o
);

  localparam int BD_AW = $clog2(BD_WORDS);

  acc_kind_e           kind;
  logic [RI_W-1:0]     reg_idx;
  logic [BD_AW-1:0]    bd_idx;
  logic [NUM_REGS-1:0] reg_we;
  logic                bd_we;
  logic                bd_re;
  logic [31:0]         reg_rd_value;
  logic [31:0]         bd_rdata;
  logic [31:0]         frame_len;

  logic                rd_fire;
  logic                rd_valid_d, rd_valid_q;
  logic                err_d, err_q;
  acc_kind_e           sel_d, sel_q;
  logic [31:0]         regval_d, regval_q;

  macreg_decode #(
    .BASE_ADDR  (BASE_ADDR),
    .SPAN_BYTES (SPAN_BYTES),
    .BD_OFFSET  (BD_OFFSET),
    .BD_WORDS   (BD_WORDS)
  ) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .kind      (kind),
    .reg_idx   (reg_idx),
    .bd_idx    (bd_idx),
    .reg_we    (reg_we),
    .bd_we     (bd_we)
  );

  macreg_file u_file (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .wdata     (req_wdata),
    .rd_idx    (reg_idx),
    .rd_value  (reg_rd_value),
    .mode      (mode_o),
    .frame_len (frame_len),
    .station   (station_addr_o)
  );

  macreg_bdram #(
    .BD_WORDS (BD_WORDS)
  ) u_bdram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bd_we),
    .re    (bd_re),
    .idx   (bd_idx),
    .wdata (req_wdata),
    .rdata (bd_rdata)
  );

  always_comb begin
    rd_fire    = req_valid && !req_write;
    bd_re      = rd_fire && (kind == ACC_BD);
    rd_valid_d = rd_fire;
    err_d      = req_valid && (kind == ACC_BAD);
    sel_d      = rd_fire ? kind : ACC_BAD;
    regval_d   = regval_q;
    if (rd_fire && (kind == ACC_REG)) regval_d = reg_rd_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      err_q      <= 1'b0;
      sel_q      <= ACC_BAD;
      regval_q   <= 32'h0;
    end else begin
      rd_valid_q <= rd_valid_d;
      err_q      <= err_d;
      sel_q      <= sel_d;
      regval_q   <= regval_d;
    end
  end

  always_comb begin
    case (sel_q)
      ACC_REG: rd_data = regval_q;
      ACC_BD:  rd_data = bd_rdata;
      default: rd_data = 32'h0;
    endcase
  end

  assign rd_valid  = rd_valid_q;
  assign acc_err   = err_q;
  assign min_len_o = frame_len[31:16];
  assign max_len_o = frame_len[15:0];

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid); // R8
  AST_NO_SPURIOUS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_write)); // R8
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && acc_err) |-> (rd_data == 32'h0)); // R7
  AST_ERR_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(req_valid)); // R9
  AST_BAD_WR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && (kind == ACC_BAD)) |=>
      ($stable(mode_o) && $stable(station_addr_o) && $stable(min_len_o))); // R6

endmodule

// File: tb/mac_regbank_bench.sv
`timescale 1ns/1ps
module mac_regbank_bench;

  localparam logic [31:0] BASE = 32'h9000_0000;
  localparam int          NREG = 18;
  localparam int          NBD  = 128;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr, req_wdata;
  logic        rd_valid, acc_err;
  logic [31:0] rd_data, mode_o;
  logic [15:0] min_len_o, max_len_o;
  logic [47:0] station_addr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mac_regbank u_mac_regbank (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .rd_valid       (rd_valid),
    .rd_data        (rd_data),
    .acc_err        (acc_err),
    .mode_o         (mode_o),
    .min_len_o      (min_len_o),
    .max_len_o      (max_len_o),
    .station_addr_o (station_addr_o)
  );

  function automatic logic [31:0] exp_reset(input int i);
    case (i)
      0: return 32'h0000_A000;  3: return 32'h12;  4: return 32'h0C;
      5: return 32'h12;         6: return 32'h003C_0600;
      7: return 32'h000F_003F;  8: return 32'h80;  10: return 32'h64;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] pat(input int i);
    return 32'hC3A5_1E69 ^ (32'(i) * 32'h0101_0101) ^ (32'(i) << 27);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rdat, output logic v, output logic e);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    rdat = rd_data; v = rd_valid; e = acc_err;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, output logic e);
    logic [31:0] r; logic v;
    access(1'b1, a, d, r, v, e);
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] r, output logic e);
    logic v;
    access(1'b0, a, 32'h0, r, v, e);
    check("R8 rd_valid after read", 64'(v), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic e, v;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    check("R8 rd_valid idle after reset", 64'(rd_valid), 64'd0);
    check("R9 acc_err idle after reset", 64'(acc_err), 64'd0);
    check("R2 min_len reset", 64'(min_len_o), 64'd60);
    check("R2 max_len reset", 64'(max_len_o), 64'd1536);
    check("R1 mode_o reset", 64'(mode_o), 64'h0000_A000);

    // R1, R2: reset values of every register
    for (int i = 0; i < NREG; i++) begin
      do_read(BASE + 32'(i * 4), r, e);
      check(i == 6 ? "R2 frame length reset" : "R1 register reset", 64'(r), 64'(exp_reset(i)));
      check("R9 no error on legal read", 64'(e), 64'd0);
    end
    @(negedge clk);
    check("R8 rd_valid drops after one cycle", 64'(rd_valid), 64'd0);

    // R10: write every register, then read back
    for (int i = 0; i < NREG; i++) begin
      do_write(BASE + 32'(i * 4), pat(i), e);
      check("R9 no error on legal write", 64'(e), 64'd0);
    end
    for (int i = 0; i < NREG; i++) begin
      do_read(BASE + 32'(i * 4), r, e);
      check(i == 17 ? "R4 station word 1 readback" : "R10 register readback",
            64'(r), 64'(i == 17 ? (pat(i) & 32'h0000_FFFF) : pat(i)));
    end
    check("R10 mode_o follows write", 64'(mode_o), 64'(pat(0)));
    check("R10 min_len follows write", 64'(min_len_o), 64'(pat(6) >> 16));
    check("R10 max_len follows write", 64'(max_len_o), 64'(pat(6) & 32'hFFFF));

    // R3, R4: station address byte packing
    do_write(BASE + 32'h40, 32'h4433_2211, e);
    do_write(BASE + 32'h44, 32'hDEAD_6655, e);
    for (int k = 0; k < 6; k++)
      check("R3/R4 station byte", 64'(station_addr_o[8*k +: 8]), 64'(8'h11 * (k + 1)));
    do_read(BASE + 32'h40, r, e);
    check("R3 station word 0 readback", 64'(r), 64'h4433_2211);
    do_read(BASE + 32'h44, r, e);
    check("R4 station word 1 upper bits zero", 64'(r), 64'h0000_6655);

    // R5: descriptor window sweep
    for (int n = 0; n < NBD; n++) do_write(BASE + 32'h400 + 32'(4 * n), pat(n + 40), e);
    for (int n = 0; n < NBD; n++) begin
      do_read(BASE + 32'h400 + 32'(4 * n), r, e);
      check("R5 descriptor entry", 64'(r), 64'(pat(n + 40)));
      check("R9 no error in descriptor window", 64'(e), 64'd0);
    end

    // R7: unmapped words inside the span
    for (int off = 32'h48; off < 32'h800; off += 4) begin
      if (off >= 32'h400 && off < 32'h600) continue;
      do_write(BASE + 32'(off), 32'hFFFF_FFFF, e);
      check("R9 error after illegal write", 64'(e), 64'd1);
      do_read(BASE + 32'(off), r, e);
      check("R7 illegal read returns zero", 64'(r), 64'd0);
      check("R9 error after illegal read", 64'(e), 64'd1);
    end
    @(negedge clk);
    check("R9 error is a single pulse", 64'(acc_err), 64'd0);

    // R6: misaligned addresses on registers and descriptors
    for (int b = 1; b < 4; b++) begin
      do_write(BASE + 32'(b), 32'h0, e);
      check("R6 error on misaligned write", 64'(e), 64'd1);
      do_read(BASE + 32'(b), r, e);
      check("R6 misaligned read zero", 64'(r), 64'd0);
      do_write(BASE + 32'h400 + 32'(b), 32'h0, e);
      do_read(BASE + 32'h44 + 32'(b), r, e);
      check("R6 misaligned read zero", 64'(r), 64'd0);
      check("R6 error on misaligned read", 64'(e), 64'd1);
    end
    // R6: outside the span
    do_write(BASE - 32'd4, 32'h0, e);
    check("R6 error below base", 64'(e), 64'd1);
    do_write(BASE + 32'h800, 32'h0, e);
    check("R6 error at span end", 64'(e), 64'd1);
    do_read(BASE + 32'h800, r, e);
    check("R6 out-of-span read zero", 64'(r), 64'd0);

    // R6, R7: state untouched by rejected writes
    check("R6 mode_o unchanged", 64'(mode_o), 64'(pat(0)));
    check("R6 station unchanged", 64'(station_addr_o), 64'h6655_4433_2211);
    do_read(BASE, r, e);
    check("R6 mode readback unchanged", 64'(r), 64'(pat(0)));
    do_read(BASE + 32'h400, r, e);
    check("R6 descriptor 0 unchanged", 64'(r), 64'(pat(40)));
    do_read(BASE + 32'h1C, r, e);
    check("R7 collision word unchanged", 64'(r), 64'(pat(7)));
    @(negedge clk);
    check("R8 rd_valid low without request", 64'(rd_valid), 64'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule